// File: doc/BRIEF.md
# Slave-SPI FPGA Configuration Sequencer

This block loads a configuration image into an SRAM-based target FPGA that listens as a slave on an SPI link. A start pulse kicks off a fixed preparation phase. The target's active-low reset and chip select are pulled low together for a minimum pulse. Reset is then released while chip select stays low. The target's configuration-done pin is checked, and the target is given a long internal clear-down interval. Chip select is then released.

After that, image bytes from an upstream producer are accepted on a valid/ready stream. The producer flags the final byte. Each byte is shifted out MSB first in SPI mode 0. Once the image is out, the done pin must have risen. If it has, a trailing run of zero bytes supplies the clocks the target needs to start the loaded design.

Each outcome is reported on the status outputs: busy, a success flag, or an error flag. A request marked as a partial update is refused on the spot. The block trusts the image contents and does not check them. Delays are counted in system clock cycles derived from the clock frequency parameter. The SPI clock divider is also a parameter.

Top module: `cfg_ld_top`

## Requirements
- R1: A start with `partial_i` low drives `creset_n_o` and `cs_n_o` low in the same cycle. Reset stays low for exactly `RST_CYC` cycles (default: at least 1 us), and chip select is low whenever reset is low.
- R2: After reset is released, the synchronized done input is sampled. If it reads high, the block raises `err_o` and returns to idle without producing any SPI clock edge.
- R3: After reset is released, chip select stays low for at least `HK_CYC` cycles (default 1200 us). It is then driven high before any image byte is clocked.
- R4: SPI uses mode 0: `sck_o` idles low, `mosi_o` changes only while `sck_o` is low, and bits go MSB first. Consecutive rising edges are at least `SCK_DIV` system cycles apart, and `sck_o` pulses only while chip select is low.
- R5: `s_ready_o` is high only during streaming, and only while the shifter is idle and the last byte has not yet been taken. The byte accepted with `s_last_i` high ends the image.
- R6: After the last image byte, chip select is raised and done is sampled. If it reads low, the block raises `err_o`, sends no further bytes and returns to idle.
- R7: If done reads high after the image, the block sends 7 zero bytes (at least 49 clocks) with chip select low. It then sets `ok_o` and returns to idle.
- R8: A start with `partial_i` high sets `err_o`, leaves `creset_n_o` and `cs_n_o` high, and does not assert `busy_o`.
- R9: On any error, reset and chip select are left high. `err_o` and `ok_o` hold until the next accepted start, which clears both.
- R10: `busy_o` is high from the cycle after an accepted full start until the block is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a load |
| partial_i | input | 1 | Request is a partial update (refused) |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the final one |
| s_ready_o | output | 1 | Block accepts the image byte |
| cdone_i | input | 1 | Target configuration-done pin (asynchronous) |
| creset_n_o | output | 1 | Target reset, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load finished correctly |
| err_o | output | 1 | Last request failed |

## Verification
The bench targets three failure points: done stuck high right after reset, done staying low after the image, and a partial-update request. A design that skipped the pre-check would go on clocking data into a target that never cleared. One that skipped the post-check would report success and send activation bytes for a failed load. A design that honoured the partial flag would pulse reset and wipe a running target.

The bench also measures the reset pulse and the chip-select clear-down window in cycles, and records every bit shifted out. This catches a design that shortens either delay, reverses the bit order, clocks data outside chip select, or miscounts the trailing zero bytes. It also checks that a failed request's error flag is cleared by the next start.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_CHK, ST_HK, ST_GAP, ST_STREAM, ST_POST, ST_ACT
  } ld_state_e;

  // cycles a two-flop synchronizer needs before a sample is trusted
  localparam int SYNC_WAIT = 3;

  function automatic int ns_to_cycles(longint clk_hz, longint ns);
    return int'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int bits_to_bytes(int bits);
    return (bits + 7) / 8;
  endfunction

  function automatic longint sck_rate(longint clk_hz, int div);
    return clk_hz / longint'(div);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfg_ld_shift.sv
module cfg_ld_shift #(
  parameter int SCK_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = $clog2(HALF + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic [7:0]    sh_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  // named events for the checks below
  logic half_end, fall_evt;
  assign half_end = act_q && (cnt_q == HALF_LAST);
  assign fall_evt = half_end && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      sck_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        sh_q  <= byte_i;
        bit_q <= '0;
        cnt_q <= '0;
        act_q <= 1'b1;
        sck_o <= 1'b0;
      end else if (act_q) begin
        if (half_end) begin
          cnt_q <= '0;
          if (!sck_o) begin
            sck_o <= 1'b1;
          end else begin
            sck_o <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_o <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign mosi_o = act_q & sh_q[7];
  assign busy_o = act_q;

  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && act_q) |=> ($stable(mosi_o) || !sck_o));
  a_r4_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_o);
endmodule

// File: rtl/cfg_ld_top.sv
module cfg_ld_top
  import cfg_ld_pkg::*;
#(
  parameter longint CLK_HZ  = 100_000_000,
  parameter int     SCK_DIV = 8,
  parameter int     RST_CYC = ns_to_cycles(CLK_HZ, 1000),
  parameter int     HK_CYC  = ns_to_cycles(CLK_HZ, 1_200_000)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [7:0] s_data_i,
  input  logic       s_valid_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       cdone_i,
  output logic       creset_n_o,
  output logic       cs_n_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o
);
  localparam int ACT_BYTES = bits_to_bytes(49);
  localparam int TMAX      = max3(RST_CYC, HK_CYC, max3(SCK_DIV, SYNC_WAIT, 1));
  localparam int TW        = $clog2(TMAX + 1);
  localparam int AW        = $clog2(ACT_BYTES + 1);
  localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] T_HK   = TW'(HK_CYC - 1);
  localparam logic [TW-1:0] T_GAP  = TW'(SCK_DIV - 1);
  localparam logic [TW-1:0] T_SYNC = TW'(SYNC_WAIT - 1);
  localparam logic [AW-1:0] A_ALL  = AW'(ACT_BYTES);

  initial begin : p_param_check
    assert (sck_rate(CLK_HZ, SCK_DIV) >= 64'd1_000_000 &&
            sck_rate(CLK_HZ, SCK_DIV) <= 64'd25_000_000 &&
            SCK_DIV >= 2 && (SCK_DIV % 2) == 0 && RST_CYC >= 1 && HK_CYC >= 1)
      else $error("cfg_ld_top: SPI clock or delay parameters out of range");
  end

  ld_state_e     state_q;
  logic [TW-1:0] tmr_q;
  logic [AW-1:0] act_cnt_q;
  logic          last_q;
  logic          done_s;

  logic tx_load, tx_busy, tx_done;
  logic [7:0] tx_byte;

  cfg_ld_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cdone_i),
    .q_o   (done_s)
  );

  // named events
  logic go_full, go_part, pre_fail, post_fail, fire, act_load, act_finish;
  assign go_full    = (state_q == ST_IDLE) && start_i && !partial_i;
  assign go_part    = (state_q == ST_IDLE) && start_i && partial_i;
  assign pre_fail   = (state_q == ST_CHK) && (tmr_q == T_SYNC) && done_s;
  assign post_fail  = (state_q == ST_POST) && (tmr_q == T_SYNC) && !done_s;
  assign s_ready_o  = (state_q == ST_STREAM) && !tx_busy && !last_q;
  assign fire       = s_ready_o && s_valid_i;
  assign act_load   = (state_q == ST_ACT) && !tx_busy && (act_cnt_q < A_ALL);
  assign act_finish = (state_q == ST_ACT) && tx_done && (act_cnt_q == A_ALL);
  assign tx_load    = fire | act_load;
  assign tx_byte    = (state_q == ST_STREAM) ? s_data_i : 8'h00;

  cfg_ld_shift #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tx_load),
    .byte_i (tx_byte),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .busy_o (tx_busy),
    .done_o (tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tmr_q     <= '0;
      act_cnt_q <= '0;
      last_q    <= 1'b0;
      ok_o      <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (start_i) begin
            ok_o   <= 1'b0;
            err_o  <= partial_i;
            last_q <= 1'b0;
            if (!partial_i) state_q <= ST_RST;
          end
        end
        ST_RST: begin
          if (tmr_q == T_RST) begin
            tmr_q   <= '0;
            state_q <= ST_CHK;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_CHK: begin
          if (tmr_q == T_SYNC) begin
            tmr_q <= '0;
            if (done_s) begin
              err_o   <= 1'b1;
              state_q <= ST_IDLE;
            end else state_q <= ST_HK;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_HK: begin
          if (tmr_q == T_HK) begin
            tmr_q   <= '0;
            state_q <= ST_GAP;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_GAP: begin
          if (tmr_q == T_GAP) begin
            tmr_q   <= '0;
            state_q <= ST_STREAM;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_STREAM: begin
          if (fire) last_q <= s_last_i;
          if (tx_done && last_q) begin
            tmr_q   <= '0;
            state_q <= ST_POST;
          end
        end
        ST_POST: begin
          if (tmr_q == T_SYNC) begin
            tmr_q     <= '0;
            act_cnt_q <= '0;
            if (!done_s) begin
              err_o   <= 1'b1;
              state_q <= ST_IDLE;
            end else state_q <= ST_ACT;
          end else tmr_q <= tmr_q + TW'(1);
        end
        ST_ACT: begin
          if (act_load) act_cnt_q <= act_cnt_q + AW'(1);
          if (act_finish) begin
            ok_o    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign creset_n_o = (state_q != ST_RST);
  assign cs_n_o     = !((state_q == ST_RST) || (state_q == ST_CHK) || (state_q == ST_HK) ||
                        (state_q == ST_STREAM) || (state_q == ST_ACT));
  assign busy_o     = (state_q != ST_IDLE);

  a_r1_cs_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !creset_n_o |-> !cs_n_o);
  a_r1_pins_together: assert property (@(posedge clk) disable iff (!rst_n)
    go_full |=> (!creset_n_o && !cs_n_o));
  a_r2_no_clock_on_pre_fail: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fail |=> (err_o && !busy_o && !sck_o));
  a_r4_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o);
  a_r5_ready_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!cs_n_o && creset_n_o));
  a_r6_post_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    post_fail |=> (err_o && cs_n_o && creset_n_o && !busy_o));
  a_r7_ok_from_act: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(act_finish));
  a_r8_partial_no_pins: assert property (@(posedge clk) disable iff (!rst_n)
    go_part |=> (err_o && creset_n_o && cs_n_o && !busy_o));
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && ok_o));
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    go_full |=> busy_o);
endmodule

// File: tb/test_cfg_ld_top.sv
module test_cfg_ld_top;
  localparam int SCK_DIV = 8;
  localparam int RST_CYC = 16;
  localparam int HK_CYC  = 60;
  localparam int NV      = 6;

  // row: {partial, pre_done, post_done, n[3:0], exp_err, exp_ok}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'd2, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 4'd2, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, partial = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, creset_n, cs_n, sck, mosi, busy, ok, err;
  logic pre_v = 1'b0, post_v = 1'b0;
  int   cur_n = 0;

  int checks = 0, fails = 0;

  // monitor state
  int cyc = 0, nrx = 0, nbits = 0;
  logic [7:0] rsh;
  logic [7:0] rx [32];
  int rst_falls, rst_fall_cyc, rst_len, rst_rise_cyc, cs_rise_cyc, first_sck, last_rise, min_per;
  int cs_mis, sck_bad;
  logic p_rst = 1'b1, p_cs = 1'b1, p_sck = 1'b0;

  wire cdone = (nrx >= cur_n) ? post_v : pre_v;

  always #2.5 clk = ~clk;

  cfg_ld_top #(.CLK_HZ(200_000_000), .SCK_DIV(SCK_DIV), .RST_CYC(RST_CYC), .HK_CYC(HK_CYC)) i_cfg_ld_top (
    .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .cdone_i(cdone), .creset_n_o(creset_n), .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi),
    .busy_o(busy), .ok_o(ok), .err_o(err)
  );

  function automatic logic [7:0] img(int k);
    return 8'(8'hC3 ^ (k * 29));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input int act, input int lim);
    checks++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (p_rst && !creset_n) begin
      rst_falls++;
      rst_fall_cyc = cyc;
    end
    if (!creset_n && cs_n) cs_mis++;
    if (!p_rst && creset_n) begin
      rst_len = cyc - rst_fall_cyc;
      rst_rise_cyc = cyc;
    end
    if (!p_cs && cs_n && rst_rise_cyc >= 0 && cs_rise_cyc < 0) cs_rise_cyc = cyc;
    if (!p_sck && sck) begin
      if (cs_n) sck_bad++;
      if (last_rise >= 0 && (cyc - last_rise) < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
      if (first_sck < 0) first_sck = cyc;
      rsh = {rsh[6:0], mosi};
      nbits++;
      if (nbits == 8) begin
        if (nrx < 32) rx[nrx] = rsh;
        nrx++;
        nbits = 0;
      end
    end
    p_rst = creset_n;
    p_cs  = cs_n;
    p_sck = sck;
  end

  task automatic run_row(input int r);
    logic prt, exp_err, exp_ok, pv, qv;
    int n, k, bad, exp_rx;
    {prt, pv, qv} = VEC[r][8:6];
    n       = int'(VEC[r][5:2]);
    exp_err = VEC[r][1];
    exp_ok  = VEC[r][0];
    @(negedge clk); #1;
    cur_n = n; pre_v = pv; post_v = qv; partial = prt;
    nrx = 0; nbits = 0; rst_falls = 0; rst_len = -1; rst_rise_cyc = -1; cs_rise_cyc = -1;
    first_sck = -1; last_rise = -1; min_per = 1 << 20; cs_mis = 0; sck_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check($sformatf("R10 busy after start row %0d", r), int'(busy), int'(!prt));
    if (!prt) check($sformatf("R9 err cleared by start row %0d", r), int'(err), 0);
    k = 0;
    forever begin
      if (!busy) break;
      s_valid = (k < n);
      s_data  = img(k);
      s_last  = (k == n - 1);
      #1;
      if (s_valid && s_ready) k++;
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    repeat (2) @(negedge clk);
    check($sformatf("R9 err_o row %0d", r), int'(err), int'(exp_err));
    check($sformatf("R7 ok_o row %0d", r), int'(ok), int'(exp_ok));
    check($sformatf("R9 pins idle row %0d", r), int'({creset_n, cs_n}), 3);
    check($sformatf("R1 reset pulses row %0d", r), rst_falls, prt ? 0 : 1);
    check($sformatf("R1 cs low during reset row %0d", r), cs_mis, 0);
    check($sformatf("R4 sck outside cs row %0d", r), sck_bad, 0);
    if (prt) check("R8 partial no pins/busy", int'({busy, creset_n, cs_n}), 3);
    if (!prt) check($sformatf("R1 reset length row %0d", r), rst_len, RST_CYC);
    exp_rx = pv ? 0 : (exp_ok ? n + 7 : (prt ? 0 : n));
    check($sformatf("R2 R6 R7 bytes clocked row %0d", r), nrx, exp_rx);
    if (pv) check("R2 no sck on pre fail", first_sck, -1);
    bad = 0;
    for (int i = 0; i < nrx && i < 32; i++)
      if (rx[i] != ((i < n) ? img(i) : 8'h00)) bad++;
    check($sformatf("R4 R7 data msb first row %0d", r), bad, 0);
    if (exp_rx > 0) begin
      check_ge($sformatf("R3 clear-down window row %0d", r), cs_rise_cyc - rst_rise_cyc, HK_CYC);
      check_ge($sformatf("R3 R5 data after window row %0d", r), first_sck - cs_rise_cyc, 1);
      check_ge($sformatf("R4 sck period row %0d", r), min_per, SCK_DIV);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset err_o", int'(err), 0);
    check("R7 reset ok_o", int'(ok), 0);
    check("R10 reset busy_o", int'(busy), 0);
    check("R1 reset pins high", int'({creset_n, cs_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 sck idle low", int'({sck, mosi}), 0);
    check("R5 ready low idle", int'(s_ready), 0);
    for (int r = 0; r < NV; r++) run_row(r);
    // directed: partial after success clears ok and sets err
    @(negedge clk); partial = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 partial sets err", int'(err), 1);
    check("R9 partial clears ok", int'(ok), 0);
    check("R8 partial keeps pins", int'({creset_n, cs_n, busy}), 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule